// File: doc/BRIEF.md
# Input Qualification Sampling Filter

This block conditions one input pin before the rest of the chip uses it. The raw level first passes through a two-flop synchroniser into the system clock domain. In the qualifying mode, the synchronised level is then sampled at a programmable period. The output changes only when a chosen number of consecutive samples all hold the same level. Short glitches are filtered out, and a level that persists long enough is passed on.

The sampling period comes from a prescaler that runs freely and is never restarted by input edges. Because of this, the phase between an input edge and the next sample is arbitrary. For a period of n clocks and m samples, a pulse of n·m clocks is always accepted. A pulse of only n·(m−1)+1 clocks may also be accepted, depending on where it falls relative to the sample ticks.

A two-bit mode input selects one of three behaviours:
- synchronised only,
- synchronised and qualified,
- unsynchronised bypass, in which the raw pin drives the output directly.

Top module: `inputQualifier`

## Requirements
- R1: While reset is asserted and just after it is released, the output is 0 and every internal stage holds 0.
- R2: With modeSel = 2'b00, the output equals pinIn as sampled two rising clock edges earlier.
- R3: With modeSel = 2'b11, the output follows pinIn combinationally, with no clock delay.
- R4: The sample tick fires every clock when periodSel = 0, and every 2·periodSel clocks otherwise (up to 510). The prescaler runs freely, with no restart on input edges. If a smaller period is written while the count is already past it, the next clock is a tick.
- R5: With modeSel = 2'b01, the output changes only on a sample tick at which the most recent m samples, including the new one, all equal the new level. Otherwise the output holds.
- R6: countSel = 0 selects m = 3 samples, and countSel = 1 selects m = 6 samples.
- R7: In qualified mode, a pulse lasting n·m clocks is always accepted. A pulse shorter than n·(m−1)+1 clocks is never accepted.
- R8: modeSel = 2'b10 behaves the same as 2'b00 (synchronised only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | Raw, possibly asynchronous pin level |
| periodSel | input | 8 | Sample period setting: 0 gives 1 clock, k gives 2·k clocks |
| modeSel | input | 2 | 00/10 synchronised, 01 qualified, 11 raw bypass |
| countSel | input | 1 | Number of agreeing samples: 0 gives 3, 1 gives 6 |
| qualOut | output | 1 | Conditioned pin level |

## Verification
The pin is driven with random toggling in every mode. This separates the two-clock synchronised path from the zero-delay bypass, and shows that the reserved mode code maps to the synchronised path. In qualified mode, random levels run across several period settings and both sample counts, including a period change made mid-count. These runs expose errors in the free-running prescaler and in the agreement window. Targeted pulses sit just below the minimum accepted width and exactly at the nominal width, for both m = 3 and m = 6, to separate a correct filter from one that accepts one sample too early or too late.

// File: rtl/qualPkg.sv
package qualPkg;
  typedef enum logic [1:0] {
    OUT_SYNC = 2'd0,
    OUT_QUAL = 2'd1,
    OUT_RAW  = 2'd2
  } outSelT;

  typedef struct packed {
    logic   sampleTick;
    logic   sixSamples;
    outSelT outSel;
  } qualStrobeT;
endpackage

// File: rtl/qualCtrl.sv
module qualCtrl
  import qualPkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] periodSel,
  input  logic [1:0]          modeSel,
  input  logic                countSel,
  output qualStrobeT          strobe
);
  localparam int CNT_W = PERIOD_W + 1;

  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] lastCount;
  logic             tick;

  // period of 2*k clocks ends at count 2*k-1; k = 0 means every clock
  assign lastCount = (periodSel == '0) ? '0 : ({periodSel, 1'b0} - CNT_W'(1));
  assign tick      = (preCnt >= lastCount);

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else if (tick) preCnt <= '0;
    else preCnt <= preCnt + CNT_W'(1);
  end

  always_comb begin
    strobe.sampleTick = tick;
    strobe.sixSamples = countSel;
    unique case (modeSel)
      2'b01:   strobe.outSel = OUT_QUAL;
      2'b11:   strobe.outSel = OUT_RAW;
      default: strobe.outSel = OUT_SYNC;
    endcase
  end

  // free-running prescaler: between ticks it only ever counts up by one
  assert_free_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && $stable(periodSel)) |=> (preCnt == CNT_W'($past(preCnt) + CNT_W'(1))));
endmodule

// File: rtl/qualPath.sv
module qualPath
  import qualPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_CNT   = 3,
  parameter int LONG_CNT    = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  qualStrobeT strobe,
  output logic       qualOut
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncOut;
  logic [LONG_CNT-1:0]    history;
  logic [LONG_CNT-1:0]    newHist;
  logic                   shortAgree;
  logic                   longAgree;
  logic                   agree;
  logic                   qualReg;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
  end
  assign syncOut = syncChain[SYNC_STAGES-1];

  assign newHist    = {history[LONG_CNT-2:0], syncOut};
  assign shortAgree = (newHist[SHORT_CNT-1:0] == '0) || (&newHist[SHORT_CNT-1:0]);
  assign longAgree  = (newHist == '0) || (&newHist);
  assign agree      = strobe.sixSamples ? longAgree : shortAgree;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      history <= '0;
      qualReg <= 1'b0;
    end else if (strobe.sampleTick) begin
      history <= newHist;
      if (agree) qualReg <= newHist[0];
    end
  end

  always_comb begin
    unique case (strobe.outSel)
      OUT_QUAL: qualOut = qualReg;
      OUT_RAW:  qualOut = pinIn;
      default:  qualOut = syncOut;
    endcase
  end

  // qualified level moves only right after a sample tick
  assert_change_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(qualReg) |-> $past(strobe.sampleTick));

  // a change is backed by the selected number of matching samples
  assert_short_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(qualReg) |-> (history[SHORT_CNT-1:0] == {SHORT_CNT{qualReg}}));
  assert_long_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(qualReg) && $past(strobe.sixSamples)) |-> (history == {LONG_CNT{qualReg}}));
endmodule

// File: rtl/inputQualifier.sv
module inputQualifier
  import qualPkg::*;
#(
  parameter int PERIOD_W    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_CNT   = 3,
  parameter int LONG_CNT    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pinIn,
  input  logic [PERIOD_W-1:0] periodSel,
  input  logic [1:0]          modeSel,
  input  logic                countSel,
  output logic                qualOut
);
  qualStrobeT strobe;

  qualCtrl #(.PERIOD_W(PERIOD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .periodSel(periodSel),
    .modeSel(modeSel), .countSel(countSel), .strobe(strobe)
  );

  qualPath #(.SYNC_STAGES(SYNC_STAGES), .SHORT_CNT(SHORT_CNT), .LONG_CNT(LONG_CNT)) path_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strobe(strobe), .qualOut(qualOut)
  );

  // warm-up counter so the delay check never reaches before reset release
  logic [1:0] warmCnt;
  always_ff @(posedge clk) begin
    if (!rstN) warmCnt <= '0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
  end

  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd2 && modeSel == 2'b00 && SYNC_STAGES == 2) |-> (qualOut == $past(pinIn, 2)));

  assert_reset_low_R1: assert property (@(posedge clk)
    (!rstN && modeSel != 2'b11) |=> (rstN || qualOut == 1'b0));
endmodule

// File: tb/inputQualifier_tb.sv
module inputQualifier_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinIn = 1'b0;
  logic [7:0] periodSel = 8'd0;
  logic [1:0] modeSel = 2'b00;
  logic       countSel = 1'b0;
  logic       qualOut;

  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 0;
  bit  sawHigh = 0;
  string phase = "R1";

  inputQualifier dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .periodSel(periodSel),
    .modeSel(modeSel), .countSel(countSel), .qualOut(qualOut)
  );

  always #4 clk = ~clk;

  // behavioural reference
  int  preM;
  bit  s1M, s2M, qM;
  bit  samples[$];

  always @(posedge clk) begin
    if (!rstN) begin
      preM = 0; s1M = 0; s2M = 0; qM = 0;
      samples.delete();
      for (int i = 0; i < 6; i++) samples.push_back(1'b0);
    end else begin
      int lim;
      int m;
      bit ok;
      lim = (periodSel == 0) ? 1 : 2 * int'(periodSel);
      if (preM >= lim - 1) begin
        preM = 0;
        samples.push_back(s2M);
        void'(samples.pop_front());
        m = countSel ? 6 : 3;
        ok = 1;
        for (int i = 6 - m; i < 6; i++) if (samples[i] != s2M) ok = 0;
        if (ok) qM = s2M;
      end else begin
        preM = preM + 1;
      end
      s2M = s1M;
      s1M = pinIn;
    end
  end

  function automatic bit expected();
    case (modeSel)
      2'b11:   return pinIn;
      2'b01:   return qM;
      default: return s2M;
    endcase
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    nChecks++;
    if (!cond) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from both edges
  always @(negedge clk) begin
    #2;
    if (!finished) begin
      if (qualOut === 1'b1) sawHigh = 1;
      if (!rstN) check(qualOut === 1'b0, "R1", int'(qualOut), 0);
      else check(qualOut === expected(), phase, int'(qualOut), int'(expected()));
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic randomPin(int n);
    repeat (n) begin
      @(negedge clk);
      pinIn = 1'($urandom_range(0, 1));
    end
  endtask

  task automatic randomSlow(int n);
    repeat (n) begin
      @(negedge clk);
      pinIn = 1'($urandom_range(0, 1));
      cycles($urandom_range(0, 20));
    end
  endtask

  task automatic pulse(int width, bit expectAccept, string req);
    @(negedge clk); pinIn = 0;
    cycles(80);
    sawHigh = 0;
    pinIn = 1;
    cycles(width);
    pinIn = 0;
    cycles(60);
    check(sawHigh == expectAccept, req, int'(sawHigh), int'(expectAccept));
  endtask

  initial begin
    cycles(4);
    check(qualOut === 1'b0, "R1", int'(qualOut), 0);
    @(negedge clk); rstN = 1;
    cycles(1);
    check(qualOut === 1'b0, "R1", int'(qualOut), 0);

    phase = "R2"; modeSel = 2'b00; randomPin(200);
    phase = "R3"; modeSel = 2'b11; randomPin(200);
    phase = "R8"; modeSel = 2'b10; randomPin(200);

    phase = "R5 R6 m3";
    modeSel = 2'b01; countSel = 0;
    for (int p = 0; p < 4; p++) begin
      periodSel = 8'(p);
      randomSlow(60);
    end
    phase = "R6 m6";
    countSel = 1;
    for (int p = 0; p < 4; p++) begin
      periodSel = 8'(p);
      randomSlow(60);
    end
    phase = "R4 period";
    periodSel = 8'd255; countSel = 0;
    randomSlow(20);
    cycles(300);
    periodSel = 8'd1;
    randomSlow(40);

    phase = "R7";
    periodSel = 8'd2; countSel = 0;
    pulse(8, 0, "R7 m3 short");
    pulse(12, 1, "R7 m3 nominal");
    periodSel = 8'd1; countSel = 1;
    pulse(10, 0, "R7 m6 short");
    pulse(12, 1, "R7 m6 nominal");

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule